// File: doc/BRIEF.md
# Pulse-Transformer PWM Encoder

This block turns one switching period's PWM decision into a pair of complementary drive bits for a small pulse transformer. The transformer carries timing to a decoder on the far side of an isolation barrier, and it also carries bias power to that side. In encoded mode the positive drive bit is high from the start of the period up to the maximum-duty point. The negative drive bit is high for the rest of the period. The instant at which the on-time ends is marked by a short notch, during which both drive bits sit at the same level. The decoder sees zero differential during the notch. The same block also produces the forward and synchronous gate enables on the local side.

The period length is fixed by a parameter in clock cycles. A one-cycle tick starts the first period, and a later tick restarts the period. After that the internal phase counter wraps on its own. A current-trip pulse ends the on-time. A minimum on-time applies, the forward drive is clamped at the maximum-duty point, and a trip that is present at the period boundary skips the whole cycle (0% duty). A plain mode replaces the encoding with an ordinary PWM on the positive bit and a reference clock on the negative bit. With the default parameters, the period is 20 cycles, the notch is 3 cycles, the minimum on-time is 4 cycles, and the maximum-duty point falls at cycle 10 (50%) or cycle 15 (75%).

Top module: `ptx_pwm_encoder`

## Requirements
- R1: A synchronous active-high reset drives all four outputs low at the next clock edge. The outputs stay low after reset is released until the first tick.
- R2: A tick in cycle t starts a period whose phase 0 is cycle t+1. A period lasts PER_CYC cycles and then wraps to phase 0 without another tick. A tick in the middle of a period restarts the period at phase 0.
- R3: In encoded mode (enc_mode_i=1) the negative bit is high, and the positive bit is low, for phases D..PER_CYC-1. The positive bit is high and the negative bit is low for phases 0..D-1, except during the notch. The two bits are never both high.
- R4: The maximum-duty point D is PER_CYC/2 when dmax75_i=0 and 3*PER_CYC/4 when dmax75_i=1. The value of dmax75_i is sampled at the edge that starts a period and holds for that whole period.
- R5: A trip pulse in phase k, with k+1 >= MINON_CYC and k+1 < D, makes the forward enable high for phases 0..k. The forward enable is low from phase k+1.
- R6: A trip pulse in phase k with k+1 < MINON_CYC is held, and the forward enable then stays high for exactly MINON_CYC phases.
- R7: When a trip ends the on-time at phase N, both drive bits are low in encoded mode for phases N..N+NOTCH_CYC-1. The notch is cut short at phase D.
- R8: With no trip, the forward enable is high for phases 0..D-1 and falls at D. No notch is produced.
- R9: A trip pulse while the forward enable is already low has no effect on any output: after the maximum-duty point, or after an earlier trip in the same period.
- R10: If the trip input is high at the edge that starts a period, that period has no forward on-time. The encoded notch then occupies phases 0..NOTCH_CYC-1.
- R11: In plain mode (enc_mode_i=0) the positive bit equals the forward enable, and the negative bit is high for phases 0..D-1 and low after.
- R12: While running, the synchronous enable is the complement of the forward enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe that starts or restarts a switching period |
| trip_i | input | 1 | Current-trip request that ends the on-time |
| enc_mode_i | input | 1 | 1 selects encoded drive, 0 selects plain PWM plus reference clock |
| dmax75_i | input | 1 | 1 selects 75% maximum duty, 0 selects 50% |
| pt_pos_o | output | 1 | Positive transformer drive bit |
| pt_neg_o | output | 1 | Negative transformer drive bit |
| fwd_en_o | output | 1 | Forward switch gate enable |
| sync_en_o | output | 1 | Synchronous switch gate enable |

## Verification
All outputs decode combinationally from registers, so each result appears in the cycle after the edge that captured its cause. Phase 0 is the cycle after the tick. The forward enable falls in the cycle after the trip cycle, the notch starts in that same cycle, and reset clears the outputs one edge after it is raised. The bench drives inputs and samples outputs at the falling edge. It compares each cycle of every period against a waveform built from the table row's on-length and notch-length, so every phase offset is checked exactly rather than within a window.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

   typedef enum logic {
      DRV_PLAIN = 1'b0,
      DRV_ENC   = 1'b1
   } drive_mode_e;

   // Phase count at which the forward drive is forced off.
   function automatic int dmax_cycles(input int per, input logic wide);
      return wide ? (per * 3) / 4 : per / 2;
   endfunction

endpackage

// File: rtl/ptx_period.sv
module ptx_period #(
   parameter int PER_CYC = 20,
   parameter int CW      = $clog2(PER_CYC)
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          tick_i,
   input  logic          dmax75_i,
   output logic          run_o,
   output logic [CW-1:0] ph_o,
   output logic [CW-1:0] dmax_o,
   output logic          start_o,
   output logic          pos_half_o
);

   localparam logic [CW-1:0] LAST_PH = CW'(PER_CYC - 1);
   localparam logic [CW-1:0] D_HALF  = CW'(ptx_pkg::dmax_cycles(PER_CYC, 1'b0));
   localparam logic [CW-1:0] D_WIDE  = CW'(ptx_pkg::dmax_cycles(PER_CYC, 1'b1));

   logic          run_q;
   logic [CW-1:0] ph_q;
   logic          wide_q;

   assign start_o = tick_i | (run_q & (ph_q == LAST_PH));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         run_q  <= 1'b0;
         ph_q   <= '0;
         wide_q <= 1'b0;
      end else if (start_o) begin
         run_q  <= 1'b1;
         ph_q   <= '0;
         wide_q <= dmax75_i;
      end else if (run_q) begin
         ph_q   <= ph_q + CW'(1);
      end
   end

   assign run_o      = run_q;
   assign ph_o       = ph_q;
   assign dmax_o     = wide_q ? D_WIDE : D_HALF;
   assign pos_half_o = run_q & (ph_q < dmax_o);

   AST_PERIOD_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_q && $past(run_q) && ph_q == '0) |-> ($past(ph_q) == LAST_PH || $past(tick_i))) // R2
      else $error("period restarted off the boundary");

   AST_PH_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      run_q |-> (ph_q <= LAST_PH)) // R2
      else $error("phase beyond period");

endmodule

// File: rtl/ptx_ontime.sv
module ptx_ontime #(
   parameter int MINON_CYC = 4,
   parameter int NOTCH_CYC = 3,
   parameter int CW        = 5
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          start_i,
   input  logic          trip_i,
   input  logic [CW-1:0] ph_i,
   input  logic [CW-1:0] dmax_i,
   output logic          on_o,
   output logic          notch_o
);

   localparam int          NW       = $clog2(NOTCH_CYC + 1);
   localparam logic [NW-1:0] NOTCH_LD = NW'(NOTCH_CYC);
   localparam logic [CW:0] MINON_V  = (CW+1)'(MINON_CYC);

   logic          on_q;
   logic          pend_q;
   logic [NW-1:0] ncnt_q;
   logic [CW:0]   ph_nx;
   logic          minon_ok;
   logic          at_dmax;
   logic          cut_now;

   assign ph_nx    = {1'b0, ph_i} + (CW+1)'(1);
   assign minon_ok = ph_nx >= MINON_V;
   assign at_dmax  = on_q & (ph_nx == {1'b0, dmax_i});
   assign cut_now  = on_q & (trip_i | pend_q) & minon_ok;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         on_q   <= 1'b0;
         pend_q <= 1'b0;
         ncnt_q <= '0;
      end else if (start_i) begin
         on_q   <= ~trip_i;
         pend_q <= 1'b0;
         ncnt_q <= trip_i ? NOTCH_LD : '0;
      end else if (at_dmax) begin
         on_q   <= 1'b0;
         pend_q <= 1'b0;
         ncnt_q <= '0;
      end else if (cut_now) begin
         on_q   <= 1'b0;
         pend_q <= 1'b0;
         ncnt_q <= NOTCH_LD;
      end else begin
         if (on_q && trip_i && !minon_ok)
            pend_q <= 1'b1;
         if (ncnt_q != '0)
            ncnt_q <= ncnt_q - NW'(1);
      end
   end

   assign on_o    = on_q;
   assign notch_o = (ncnt_q != '0);

   AST_DMAX_CLAMP: assert property (@(posedge clk_i) disable iff (rst_i)
      on_q |-> (ph_i < dmax_i)) // R4
      else $error("forward drive past max duty");

   AST_MIN_ON: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(on_q) |-> ((ph_i >= CW'(MINON_CYC)) || (ph_i == '0))) // R6
      else $error("on-time shorter than minimum");

endmodule

// File: rtl/ptx_drive.sv
module ptx_drive #(
   parameter bit NOTCH_HIGH = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic enc_i,
   input  logic run_i,
   input  logic pos_half_i,
   input  logic on_i,
   input  logic notch_i,
   output logic pt_pos_o,
   output logic pt_neg_o,
   output logic fwd_o,
   output logic sync_o
);

   import ptx_pkg::*;

   drive_mode_e mode;
   logic        in_notch;
   logic        enc_pos;
   logic        enc_neg;

   assign mode     = drive_mode_e'(enc_i);
   assign in_notch = notch_i & pos_half_i;

   generate
      if (NOTCH_HIGH) begin : g_notch_hi
         assign enc_pos = pos_half_i;
         assign enc_neg = run_i & (~pos_half_i | in_notch);
      end else begin : g_notch_lo
         assign enc_pos = pos_half_i & ~in_notch;
         assign enc_neg = run_i & ~pos_half_i;

         AST_NO_SHOOT: assert property (@(posedge clk_i) disable iff (rst_i)
            (mode == DRV_ENC) |-> !(pt_pos_o && pt_neg_o)) // R3
            else $error("both drive bits high");

         AST_NOTCH_ON_CUT: assert property (@(posedge clk_i) disable iff (rst_i)
            ((mode == DRV_ENC) && $fell(on_i) && pos_half_i) |-> (!pt_pos_o && !pt_neg_o)) // R7
            else $error("no notch after on-time cut");
      end
   endgenerate

   always_comb begin
      if (mode == DRV_ENC) begin
         pt_pos_o = enc_pos;
         pt_neg_o = enc_neg;
      end else begin
         pt_pos_o = on_i;
         pt_neg_o = pos_half_i;
      end
   end

   assign fwd_o  = on_i;
   assign sync_o = run_i & ~on_i;

   AST_NEG_HALF: assert property (@(posedge clk_i) disable iff (rst_i)
      ((mode == DRV_ENC) && run_i && !pos_half_i) |-> (pt_neg_o && !pt_pos_o && !fwd_o)) // R3
      else $error("negative half not driven");

endmodule

// File: rtl/ptx_pwm_encoder.sv
module ptx_pwm_encoder #(
   parameter int PER_CYC    = 20,
   parameter int NOTCH_CYC  = 3,
   parameter int MINON_CYC  = 4,
   parameter bit NOTCH_HIGH = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic tick_i,
   input  logic trip_i,
   input  logic enc_mode_i,
   input  logic dmax75_i,
   output logic pt_pos_o,
   output logic pt_neg_o,
   output logic fwd_en_o,
   output logic sync_en_o
);

   localparam int CW = $clog2(PER_CYC);

   generate
      if (PER_CYC < 8 || (PER_CYC % 4) != 0) begin : g_bad_per
         $error("PER_CYC must be a multiple of 4 and at least 8");
      end
      if (MINON_CYC < 1 || MINON_CYC >= PER_CYC / 2) begin : g_bad_minon
         $error("MINON_CYC must lie in 1 .. PER_CYC/2-1");
      end
      if (NOTCH_CYC < 1 || NOTCH_CYC >= PER_CYC / 2) begin : g_bad_notch
         $error("NOTCH_CYC must lie in 1 .. PER_CYC/2-1");
      end
   endgenerate

   logic          run;
   logic [CW-1:0] ph;
   logic [CW-1:0] dmax;
   logic          start;
   logic          pos_half;
   logic          on;
   logic          notch;

   ptx_period #(.PER_CYC(PER_CYC), .CW(CW)) period_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .tick_i     (tick_i),
      .dmax75_i   (dmax75_i),
      .run_o      (run),
      .ph_o       (ph),
      .dmax_o     (dmax),
      .start_o    (start),
      .pos_half_o (pos_half)
   );

   ptx_ontime #(.MINON_CYC(MINON_CYC), .NOTCH_CYC(NOTCH_CYC), .CW(CW)) ontime_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .start_i (start),
      .trip_i  (trip_i),
      .ph_i    (ph),
      .dmax_i  (dmax),
      .on_o    (on),
      .notch_o (notch)
   );

   ptx_drive #(.NOTCH_HIGH(NOTCH_HIGH)) drive_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .enc_i      (enc_mode_i),
      .run_i      (run),
      .pos_half_i (pos_half),
      .on_i       (on),
      .notch_i    (notch),
      .pt_pos_o   (pt_pos_o),
      .pt_neg_o   (pt_neg_o),
      .fwd_o      (fwd_en_o),
      .sync_o     (sync_en_o)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      !run |-> !(pt_pos_o || pt_neg_o || fwd_en_o || sync_en_o)) // R1
      else $error("outputs active while idle");

endmodule

// File: tb/ptx_pwm_encoder_tb_top.sv
module ptx_pwm_encoder_tb_top;

   localparam int PER   = 20;
   localparam int NOTCH = 3;
   localparam int MINON = 4;
   localparam int NV    = 12;

   // stimulus: mode, duty select, trip phase (-1 = held at boundary, 99 = none)
   // expected: forward on-length, notch length
   localparam int V_ENC  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 0};
   localparam int V_D75  [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0};
   localparam int V_TRIP [NV] = '{5, 99, 1, 8, 12, 99, -1, 5, 11, 15, 3, -1};
   localparam int V_ON   [NV] = '{6, 10, 4, 9, 13, 15, 0, 6, 12, 10, 4, 0};
   localparam int V_NT   [NV] = '{3, 0, 3, 3, 3, 0, 3, 3, 3, 0, 3, 3};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic trip = 1'b0;
   logic enc = 1'b1;
   logic d75 = 1'b0;
   logic pt_pos, pt_neg, fwd_en, sync_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ptx_pwm_encoder #(.PER_CYC(PER), .NOTCH_CYC(NOTCH), .MINON_CYC(MINON)) dut_i (
      .clk_i      (clk),
      .rst_i      (rst),
      .tick_i     (tick),
      .trip_i     (trip),
      .enc_mode_i (enc),
      .dmax75_i   (d75),
      .pt_pos_o   (pt_pos),
      .pt_neg_o   (pt_neg),
      .fwd_en_o   (fwd_en),
      .sync_en_o  (sync_en)
   );

   function automatic logic [3:0] model(int e, int w, int on_len, int nl, int c);
      int  d;
      bit  pos, fg, nt, pp, pn;
      d   = w ? (PER * 3) / 4 : PER / 2;
      pos = (c < d);
      fg  = (c < on_len);
      nt  = (nl > 0) && (c >= on_len) && (c < on_len + nl) && pos;
      if (e != 0) begin
         pp = pos && !nt;
         pn = !pos;
      end else begin
         pp = fg;
         pn = pos;
      end
      return {pp, pn, fg, !fg};
   endfunction

   function automatic string vreq(int v);
      case (v)
         0:       return "R5 R3 R12";
         1:       return "R8 R3";
         2:       return "R6 min on-time";
         3:       return "R7 notch cut at max duty";
         4:       return "R4 wide duty trip";
         5:       return "R4 wide duty clamp";
         6:       return "R10 zero duty encoded";
         7:       return "R11 plain half";
         8:       return "R11 plain wide";
         9:       return "R9 trip after max duty";
         10:      return "R6 min on-time boundary";
         default: return "R10 zero duty plain";
      endcase
   endfunction

   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] got;
      got = {pt_pos, pt_neg, fwd_en, sync_en};
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (pos,neg,fwd,sync) at %0t", req, got, exp, $time);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", 4'b0000);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 idle before tick", 4'b0000);

      enc  = V_ENC[0][0];
      d75  = V_D75[0][0];
      trip = (V_TRIP[0] == -1);
      tick = 1'b1;
      for (int v = 0; v < NV; v++) begin
         for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            tick = 1'b0;
            chk(vreq(v), model(V_ENC[v], V_D75[v], V_ON[v], V_NT[v], c));
            trip = (c == V_TRIP[v]);
            if (c == PER - 1 && v + 1 < NV) begin
               enc = V_ENC[v + 1][0];
               d75 = V_D75[v + 1][0];
               if (V_TRIP[v + 1] == -1) trip = 1'b1;
            end
         end
      end

      // reset in the middle of a running period
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 reset while running", 4'b0000);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 idle after reset", 4'b0000);
      @(negedge clk);
      chk("R1 idle after reset", 4'b0000);

      // tick restart in mid period
      enc  = 1'b1;
      d75  = 1'b0;
      trip = 1'b0;
      tick = 1'b1;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         tick = 1'b0;
         chk("R2 first period", model(1, 0, 10, 0, c));
         if (c == 4) tick = 1'b1;
      end
      for (int c = 0; c < PER; c++) begin
         @(negedge clk);
         tick = 1'b0;
         chk("R2 restarted period", model(1, 0, 10, 0, c));
      end
      @(negedge clk);
      chk("R2 wrap to phase 0", model(1, 0, 10, 0, 0));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule